// File: doc/BRIEF.md
# Dual-Rate System Clock Rate Controller

This block sets the pace of the general system clock from a fast source clock. The output is not a clock. It is a clock-enable pulse, one source cycle wide, that repeats every 2^N source cycles. N comes from one of two programmable 3-bit factors: a fast factor and a slow factor. The power mode decides which factor applies. The two fast modes (running and dozing) use the fast factor, and the two slow modes use the slow factor.

In the slow modes, three wake conditions can raise the clock to the fast factor for as long as they last:

- a pending interrupt request, gated by the interrupt wake enable;
- the core being out of its power-saving state, also gated by the interrupt wake enable;
- a busy communication microcontroller, gated by its own wake enable.

A change of factor is applied only when the divider counter wraps, so no period is ever cut short. After the last wake condition drops, the fast rate stays in place for one more divided period.

Top module: `sysclk_rate_ctrl`

## Requirements
- R1: While reset is asserted, and for the first cycles after it is released, `tick` is high on every source cycle and `fast_active` is 1. Once the divider takes its first factor, it runs at the selected rate.
- R2: A factor value N in 0..7 gives a `tick` period of 2^N source cycles. N = 0 gives a pulse on every cycle.
- R3: With `mode` 2'b00 (running fast) or 2'b01 (dozing fast), the period follows `fast_log2` and `fast_active` is 1.
- R4: With `mode` 2'b10 (running slow) or 2'b11 (dozing slow) and no enabled wake condition, the period follows `slow_log2` and `fast_active` is 0.
- R5: A change of `mode` or of a factor never shortens or stretches the period in progress. The new rate begins only after the next `tick`.
- R6: In a slow mode, `irq_pend` with `irq_wake_en` set gives the fast period and `fast_active` = 1.
- R7: In a slow mode, `core_awake` with `irq_wake_en` set gives the fast period and `fast_active` = 1.
- R8: In a slow mode, `risc_busy` with `risc_wake_en` set gives the fast period and `fast_active` = 1.
- R9: A wake condition whose enable is clear has no effect on the period or on `fast_active`.
- R10: When the last enabled condition drops during a fast period, the next period still runs fast. The one after that returns to the slow factor.
- R11: In running-slow mode, rewriting `slow_log2` changes the period at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Power mode: 00 running fast, 01 dozing fast, 10 running slow, 11 dozing slow |
| fast_log2 | input | 3 | Fast-rate factor N (divide by 2^N) |
| slow_log2 | input | 3 | Slow-rate factor N (divide by 2^N) |
| irq_wake_en | input | 1 | Enables the interrupt and core-awake wake conditions |
| risc_wake_en | input | 1 | Enables the microcontroller wake condition |
| irq_pend | input | 1 | Interrupt request pending |
| core_awake | input | 1 | Core not in its power-saving state |
| risc_busy | input | 1 | Communication microcontroller has a request or is running one |
| tick | output | 1 | One-cycle enable pulse at the divided rate |
| fast_active | output | 1 | 1 while the current period uses the fast factor |

## Verification
The hardest behaviour to reach is the rate change mid-period, because a test that waits for steady state never sees it. The bench first lets a long slow period settle. It then switches the mode three cycles after a pulse and checks that the gap still totals the full slow length before the short fast gaps start. The fall-back after a wake condition is tested the same way. The interrupt is dropped on a pulse cycle, and the bench checks for exactly one more fast gap followed by a slow one.

// File: rtl/sysclk_rate_pkg.sv
package sysclk_rate_pkg;

  typedef enum logic [1:0] {
    MODE_RUN_FAST  = 2'b00,
    MODE_IDLE_FAST = 2'b01,
    MODE_RUN_SLOW  = 2'b10,
    MODE_IDLE_SLOW = 2'b11
  } pwr_mode_e;

  // The upper mode bit marks the slow-rate modes.
  function automatic logic mode_is_slow(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/sysclk_wake_eval.sv
module sysclk_wake_eval #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cond,
  input  logic [NUM_SRC-1:0] cond_en,
  input  logic               wrap,
  output logic               boost
);

  logic [NUM_SRC-1:0] live;
  logic               wake_now;
  logic               seen_q, seen_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign live[i] = cond[i] & cond_en[i];
  end

  assign wake_now = |live;

  // Remembers any enabled condition seen since the last boundary.
  always_comb begin
    seen_d = seen_q;
    if (wrap) seen_d = 1'b0;
    else if (wake_now) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  assign boost = wake_now | seen_q;

  AST_BOOST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wake_now) |=> (boost == wake_now)) else $error("boost held over boundary"); // R10

endmodule

// File: rtl/sysclk_div_counter.sv
module sysclk_div_counter #(
  parameter int FACT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FACT_W-1:0] sel_log2,
  input  logic              sel_fast,
  output logic              tick,
  output logic              fast_active
);

  localparam int CNT_W = (1 << FACT_W) - 1;

  logic [FACT_W-1:0] act_q, act_d;
  logic              fast_q, fast_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W:0]    lim_wide;
  logic [CNT_W-1:0]  limit;
  logic              wrap;

  assign lim_wide = ({{CNT_W{1'b0}}, 1'b1} << act_q) - 1'b1;
  assign limit    = lim_wide[CNT_W-1:0];
  assign wrap     = (cnt_q == limit);

  // A new factor and rate are taken only at the boundary.
  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    act_d  = act_q;
    fast_d = fast_q;
    if (wrap) begin
      cnt_d  = '0;
      act_d  = sel_log2;
      fast_d = sel_fast;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= '0;
      fast_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      fast_q <= fast_d;
    end
  end

  assign tick        = wrap;
  assign fast_active = fast_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit) else $error("counter past limit"); // R2
  AST_FACTOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(act_q) && $stable(fast_active))) else $error("rate changed mid-period"); // R5

endmodule

// File: rtl/sysclk_rate_ctrl.sv
module sysclk_rate_ctrl
  import sysclk_rate_pkg::*;
#(
  parameter int FACT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [FACT_W-1:0] fast_log2,
  input  logic [FACT_W-1:0] slow_log2,
  input  logic              irq_wake_en,
  input  logic              risc_wake_en,
  input  logic              irq_pend,
  input  logic              core_awake,
  input  logic              risc_busy,
  output logic              tick,
  output logic              fast_active
);

  localparam int NUM_SRC = 3;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_SRC-1:0] cond, cond_en;
  logic               boost;
  logic               sel_fast;
  logic [FACT_W-1:0]  sel_log2;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cond    = {risc_busy, core_awake, irq_pend};
  assign cond_en = {risc_wake_en, irq_wake_en, irq_wake_en};

  sysclk_wake_eval #(.NUM_SRC(NUM_SRC)) i_wake (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cond    (cond),
    .cond_en (cond_en),
    .wrap    (tick),
    .boost   (boost)
  );

  always_comb begin
    sel_fast = !mode_is_slow(mode) || boost;
    sel_log2 = sel_fast ? fast_log2 : slow_log2;
  end

  sysclk_div_counter #(.FACT_W(FACT_W)) i_div (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sel_log2    (sel_log2),
    .sel_fast    (sel_fast),
    .tick        (tick),
    .fast_active (fast_active)
  );

  AST_FAST_MODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tick && !mode[1]) |=> fast_active) else $error("fast mode not fast"); // R3
  AST_SLOW_MODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tick && mode[1] && !boost) |=> !fast_active) else $error("slow mode not slow"); // R4

endmodule

// File: tb/test_sysclk_rate_ctrl.sv
`timescale 1ns/1ps
module test_sysclk_rate_ctrl;

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] hi;
    logic [2:0] lo;
    logic       ien, ren, irq, awk, rsk;
    logic [7:0] per;
    logic       fast;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 3'd2, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4,   1'b1, 4'd3},  // R3
    '{2'b01, 3'd0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,   1'b1, 4'd3},  // R3 R2
    '{2'b10, 3'd1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,   1'b0, 4'd4},  // R4
    '{2'b11, 3'd1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd128, 1'b0, 4'd4},  // R4 R2
    '{2'b10, 3'd1, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2,   1'b1, 4'd6},  // R6
    '{2'b11, 3'd2, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4,   1'b1, 4'd7},  // R7
    '{2'b10, 3'd0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1,   1'b1, 4'd8},  // R8
    '{2'b10, 3'd1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd8,   1'b0, 4'd9},  // R9
    '{2'b11, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4,   1'b0, 4'd9},  // R9
    '{2'b10, 3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,   1'b0, 4'd11}  // R11
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [2:0] fast_log2, slow_log2;
  logic       irq_wake_en, risc_wake_en, irq_pend, core_awake, risc_busy;
  logic       tick, fast_active;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sysclk_rate_ctrl i_sysclk_rate_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fast_log2(fast_log2),
    .slow_log2(slow_log2), .irq_wake_en(irq_wake_en), .risc_wake_en(risc_wake_en),
    .irq_pend(irq_pend), .core_awake(core_awake), .risc_busy(risc_busy),
    .tick(tick), .fast_active(fast_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycles from the current negedge to the next negedge that sees tick.
  task automatic tick_gap(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!tick && g < 400);
    if (g >= 400) chk(1'b0, "watchdog", g, 0);
  endtask

  task automatic settle(input int n);
    int g;
    for (int k = 0; k < n; k++) tick_gap(g);
  endtask

  initial begin
    int g;
    int first;
    rst_n = 1'b0; mode = 2'b10; fast_log2 = 3'd1; slow_log2 = 3'd3;
    irq_wake_en = 1'b0; risc_wake_en = 1'b0;
    irq_pend = 1'b0; core_awake = 1'b0; risc_busy = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(tick == 1'b1, "R1 tick in reset", tick, 1);
    chk(fast_active == 1'b1, "R1 fast_active in reset", fast_active, 1);
    rst_n = 1'b1;
    first = 0;
    for (int k = 0; k < 6 && first == 0; k++) begin
      tick_gap(g);
      if (g != 1) first = g;
    end
    chk(first == 8, "R1 first divided period", first, 8);

    // Table walk: R2 R3 R4 R6 R7 R8 R9 R11
    for (int v = 0; v < NV; v++) begin
      mode = VECS[v].mode; fast_log2 = VECS[v].hi; slow_log2 = VECS[v].lo;
      irq_wake_en = VECS[v].ien; risc_wake_en = VECS[v].ren;
      irq_pend = VECS[v].irq; core_awake = VECS[v].awk; risc_busy = VECS[v].rsk;
      settle(3);
      tick_gap(g);
      chk(g == int'(VECS[v].per), $sformatf("R%0d period row %0d", VECS[v].req, v), g, VECS[v].per);
      chk(fast_active == VECS[v].fast, $sformatf("R%0d rate row %0d", VECS[v].req, v),
          fast_active, VECS[v].fast);
    end

    // R5: mode change three cycles into a slow period
    irq_wake_en = 1'b0; risc_wake_en = 1'b0; irq_pend = 1'b0; core_awake = 1'b0; risc_busy = 1'b0;
    mode = 2'b10; fast_log2 = 3'd1; slow_log2 = 3'd3;
    settle(3);
    repeat (3) @(negedge clk);
    mode = 2'b00;
    tick_gap(g);
    chk(g + 3 == 8, "R5 period in progress kept", g + 3, 8);
    chk(fast_active == 1'b0, "R5 old rate kept", fast_active, 0);
    tick_gap(g);
    chk(g == 2, "R5 new period after boundary", g, 2);
    chk(fast_active == 1'b1, "R5 new rate after boundary", fast_active, 1);

    // R10: fall-back one period after the condition drops
    mode = 2'b10; irq_wake_en = 1'b1; irq_pend = 1'b1;
    settle(3);
    irq_pend = 1'b0;
    tick_gap(g);
    chk(g == 2, "R10 one more fast period", g, 2);
    chk(fast_active == 1'b1, "R10 still fast", fast_active, 1);
    tick_gap(g);
    chk(g == 8, "R10 back to slow period", g, 8);
    chk(fast_active == 1'b0, "R10 slow again", fast_active, 0);

    // R9: masked microcontroller request during a slow period
    risc_wake_en = 1'b0; risc_busy = 1'b1; irq_wake_en = 1'b0; core_awake = 1'b1;
    tick_gap(g);
    chk(g == 8 && fast_active == 1'b0, "R9 masked sources ignored", g, 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule